// File: doc/BRIEF.md
# Capability Discovery Reader

The block lets software find out which hardware capabilities are present through one control/status register. The register works as a window into a read-only table. A write to the register sets an internal word pointer. A read returns the table word that the pointer selects. When the write also sets the step flag, every read that lands inside the table moves the pointer forward by one word. Software can then stream through a record without writing the register again.

The table is a chain of capability records. Each record begins with a header word. The header holds the capability identifier and the word offset of the following record. After the header come payload words, whose meaning depends on the identifier. Typical payloads describe a configuration string, debug support or instruction-set features. A next offset of zero ends the chain.

Software walks the chain in a fixed way. It writes an offset, reads the header, and either steps through the payload or jumps to the next header. The table contents are generated from parameters, so no memory image is needed.

Top module: `cap_disc_reader`

## Requirements
- R1: After reset the pointer is at offset 0 and stepping is off, so every read returns the header of the first record until the register is written.
- R2: A write loads the pointer from write-data bits [PTR_W-1:0] and the step flag from bit 31. Bits 30 down to PTR_W have no effect.
- R3: While the read strobe is high, the read data equals the table word at the current pointer. While the read strobe is low, the read data is zero.
- R4: With stepping on, a read at an in-table offset returns the word at that offset, and the pointer holds offset+1 from the next cycle on.
- R5: With stepping off, repeated reads return the same word and the pointer does not change.
- R6: A read at an offset of TABLE_WORDS or more returns zero and leaves the pointer unchanged, even with stepping on.
- R7: When a write and a read fall in the same cycle, the read returns the word at the old pointer. The pointer then takes the written value and is not incremented.
- R8: Record k (0 ≤ k < NUM_REC) starts at offset k·(1+PAY_WORDS). Its header holds the identifier 0x0010+k in bits [31:16] and the next record's offset in bits [15:0]. For the last record, bits [15:0] are zero.
- R9: Payload word p of record k, at offset k·(1+PAY_WORDS)+1+p, has the value 0xA5000000 + 256·k + p.
- R10: With no read and no write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Write data: bit 31 is the step flag, the low PTR_W bits are the offset |
| csr_rd | input | 1 | Register read strobe |
| csr_rdata | output | 32 | Table word at the pointer, or zero |

## Verification
The bench writes every offset from zero to a few words past the end of the table with stepping off, reads each one twice, and compares the result with the layout formula. This tells header words apart from payload words and from the zero returned out of range. A second pass streams the whole table with stepping on. This separates a correct step from a skipped or repeated word, and shows that the pointer stops at the end of the table. Further tests follow the chain of next fields until it ends. They also read with stepping on from the highest offset, where a moving pointer would wrap to live data. Finally they write with junk in the ignored bits and overlap a write with a read in one cycle, which tells whether the write or the step wins.

// File: rtl/cap_pkg.sv
// Package: shared word type and the arithmetic that defines the table layout.
// Assumes offsets and identifiers fit in 16 bits.
package cap_pkg;

    localparam int WORD_W   = 32;
    localparam int STEP_BIT = 31;
    localparam logic [15:0] ID_BASE  = 16'h0010;
    localparam logic [31:0] PAY_BASE = 32'hA500_0000;

    typedef logic [WORD_W-1:0] cap_word_t;

    // Word stored at offset off, for nrec records that each carry pay payload words.
    function automatic cap_word_t table_word(int off, int nrec, int pay);
        int rw;
        int k;
        int j;
        logic [15:0] nxt;
        rw = 1 + pay;
        k  = off / rw;
        j  = off % rw;
        if (j == 0) begin
            nxt = (k == nrec - 1) ? 16'd0 : 16'((k + 1) * rw);
            return {ID_BASE + 16'(k), nxt};
        end
        return PAY_BASE + 32'(k * 256) + 32'(j - 1);
    endfunction

endpackage

// File: rtl/cap_rom.sv
// Module cap_rom: constant table of capability records, built at
// elaboration from cap_pkg::table_word. It returns zero for any address
// at or beyond TABLE_WORDS. Assumes TABLE_WORDS < 2**PTR_W.
module cap_rom #(
    parameter int PTR_W     = 8,
    parameter int NUM_REC   = 4,
    parameter int PAY_WORDS = 2
) (
    input  logic [PTR_W-1:0]       addr,
    output cap_pkg::cap_word_t     word
);
    localparam int TABLE_WORDS = NUM_REC * (1 + PAY_WORDS);

    cap_pkg::cap_word_t tbl [TABLE_WORDS];

    // One constant word per table entry.
    for (genvar g = 0; g < TABLE_WORDS; g++) begin : g_word
        assign tbl[g] = cap_pkg::table_word(g, NUM_REC, PAY_WORDS);
    end

    // Look up the word, forcing zero outside the table.
    always_comb begin
        word = '0;
        if (addr < PTR_W'(TABLE_WORDS)) begin
            word = tbl[addr];
        end
    end
endmodule

// File: rtl/cap_ptr.sv
// Module cap_ptr: word pointer and step flag. A write has priority and loads
// both. A read with stepping on advances the pointer only while it is inside
// the table. Synchronous active-low reset clears both to zero.
module cap_ptr #(
    parameter int PTR_W       = 8,
    parameter int TABLE_WORDS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  cap_pkg::cap_word_t         wdata,
    input  logic                       rd,
    output logic [PTR_W-1:0]           ptr,
    output logic                       step_en
);
    logic in_table;
    logic unused_wbits;

    // Upper data bits carry no function.
    assign unused_wbits = ^wdata[cap_pkg::STEP_BIT-1:PTR_W];

    // Pointer is inside the table.
    assign in_table = (ptr < PTR_W'(TABLE_WORDS));

    // Pointer and step flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            step_en <= 1'b0;
        end else if (wr) begin
            ptr     <= wdata[PTR_W-1:0];
            step_en <= wdata[cap_pkg::STEP_BIT];
        end else if (rd && step_en && in_table) begin
            ptr     <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cap_disc_reader.sv
// Module cap_disc_reader: top of the capability discovery window. It joins
// the pointer register to the record table. Read data is combinational from
// the current pointer, so a read returns the old location in the same cycle
// that a step or write takes effect for the next one.
module cap_disc_reader #(
    parameter int PTR_W     = 8,
    parameter int NUM_REC   = 4,
    parameter int PAY_WORDS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    input  logic        csr_rd,
    output logic [31:0] csr_rdata
);
    localparam int TABLE_WORDS = NUM_REC * (1 + PAY_WORDS);

    logic [PTR_W-1:0]   cur_ptr;
    logic               step_en;
    cap_pkg::cap_word_t rom_word;

    cap_ptr #(.PTR_W(PTR_W), .TABLE_WORDS(TABLE_WORDS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (csr_wr),
        .wdata   (csr_wdata),
        .rd      (csr_rd),
        .ptr     (cur_ptr),
        .step_en (step_en)
    );

    cap_rom #(.PTR_W(PTR_W), .NUM_REC(NUM_REC), .PAY_WORDS(PAY_WORDS)) u_rom (
        .addr (cur_ptr),
        .word (rom_word)
    );

    // Present the word only while a read is strobed.
    assign csr_rdata = csr_rd ? rom_word : '0;
endmodule

// File: rtl/cap_disc_checker.sv
// Module cap_disc_checker: temporal checks on the pointer and the read port,
// bound into cap_disc_reader.
module cap_disc_checker #(
    parameter int PTR_W       = 8,
    parameter int TABLE_WORDS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic [31:0]      csr_wdata,
    input logic             csr_rd,
    input logic [31:0]      csr_rdata,
    input logic [PTR_W-1:0] ptr,
    input logic             step_en
);
    a_r1_reset_ptr: assert property (@(posedge clk) !rst_n |=> (ptr == '0 && !step_en));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (ptr == $past(csr_wdata[PTR_W-1:0]) && step_en == $past(csr_wdata[31])));

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |-> csr_rdata == '0);

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !csr_wr && step_en && ptr < PTR_W'(TABLE_WORDS)) |=> ptr == $past(ptr) + 1'b1);

    a_r5_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !csr_wr && !step_en) |=> $stable(ptr));

    a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && ptr >= PTR_W'(TABLE_WORDS)) |-> csr_rdata == '0);

    a_r6_oob_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !csr_wr && ptr >= PTR_W'(TABLE_WORDS)) |=> $stable(ptr));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rd && !csr_wr) |=> ($stable(ptr) && $stable(step_en)));
endmodule

bind cap_disc_reader cap_disc_checker #(.PTR_W(PTR_W), .TABLE_WORDS(TABLE_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rd    (csr_rd),
    .csr_rdata (csr_rdata),
    .ptr       (cur_ptr),
    .step_en   (step_en)
);

// File: tb/tb_cap_disc_reader.sv
module tb_cap_disc_reader;
    localparam int PTR_W = 8;
    localparam int NREC  = 4;
    localparam int PAY   = 2;
    localparam int TW    = NREC * (1 + PAY);
    localparam logic [31:0] STEP = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        csr_rd = 1'b0;
    logic [31:0] csr_rdata;
    int checks = 0;
    int errors = 0;

    cap_disc_reader #(.PTR_W(PTR_W), .NUM_REC(NREC), .PAY_WORDS(PAY)) dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .csr_rdata(csr_rdata));

    always #2 clk = ~clk;

    // Expected word from the layout requirements R8 and R9.
    function automatic logic [31:0] expw(int off);
        int k;
        int j;
        if (off >= TW) return 32'd0;
        k = off / (1 + PAY);
        j = off % (1 + PAY);
        if (j == 0)
            return {16'(16 + k), (k == NREC - 1) ? 16'd0 : 16'((k + 1) * (1 + PAY))};
        return 32'hA500_0000 + 32'(k * 256) + 32'(j - 1);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample before the rising edge.
    task automatic cyc(logic w, logic [31:0] d, logic r, output logic [31:0] got);
        @(negedge clk);
        csr_wr = w; csr_wdata = d; csr_rd = r;
        #1 got = csr_rdata;
        @(posedge clk);
        #1 csr_wr = 1'b0; csr_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] g;
        int off;
        int nrec;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cyc(0, 0, 1, g); check("R1", g, expw(0));
        cyc(0, 0, 1, g); check("R5", g, expw(0));
        cyc(0, 0, 0, g); check("R3", g, 32'd0);

        for (int o = 0; o < TW + 4; o++) begin
            cyc(1, 32'(o), 0, g);
            cyc(0, 0, 1, g); check(o < TW ? "R3" : "R6", g, expw(o));
            cyc(0, 0, 1, g); check("R5", g, expw(o));
        end

        cyc(1, STEP, 0, g);
        for (int o = 0; o < TW + 2; o++) begin
            cyc(0, 0, 1, g); check("R4", g, expw(o));
        end

        cyc(1, STEP | 32'd255, 0, g);
        cyc(0, 0, 1, g); check("R6", g, 32'd0);
        cyc(0, 0, 1, g); check("R6", g, 32'd0);

        off = 0; nrec = 0;
        for (int n = 0; n < NREC + 2; n++) begin
            cyc(1, 32'(off), 0, g);
            cyc(0, 0, 1, g);
            check("R8", {16'd0, g[31:16]}, 32'(16 + nrec));
            nrec++;
            off = int'(g[15:0]);
            if (off == 0) break;
        end
        check("R8", 32'(nrec), 32'(NREC));

        cyc(1, 32'h7F00_0003, 0, g);
        cyc(0, 0, 1, g); check("R2", g, expw(3));
        cyc(0, 0, 1, g); check("R2", g, expw(3));

        cyc(1, STEP, 0, g);
        cyc(0, 0, 1, g); check("R4", g, expw(0));
        cyc(1, 32'd5, 1, g); check("R7", g, expw(1));
        cyc(0, 0, 1, g); check("R7", g, expw(5));
        cyc(0, 0, 1, g); check("R7", g, expw(5));

        cyc(1, STEP | 32'd7, 0, g);
        cyc(0, 0, 0, g); check("R10", g, 32'd0);
        cyc(0, 0, 0, g);
        cyc(0, 0, 1, g); check("R10", g, expw(7));

        cyc(1, STEP | 32'(TW - 1), 0, g);
        cyc(0, 0, 1, g); check("R4", g, expw(TW - 1));
        cyc(0, 0, 1, g); check("R6", g, 32'd0);
        cyc(0, 0, 1, g); check("R6", g, 32'd0);

        rst_n = 1'b0;
        cyc(0, 0, 0, g);
        rst_n = 1'b1;
        cyc(0, 0, 1, g); check("R1", g, expw(0));
        cyc(0, 0, 1, g); check("R1", g, expw(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule